// File: doc/BRIEF.md
# Dual-Rail Table-Driven Logic Unit

This unit evaluates one two-input Boolean function (AND, OR or XOR) on operands held in a complementary two-wire code. Each operand enters as a full byte, and only its two least significant bits carry meaning: `01` stands for true and `10` for false. The two operands are reduced to those two bits and joined into a four-bit address. The result is then read out of a per-function table. No Boolean gate on the data path combines operand values.

The table holds a legal rail pair only at the four addresses where both halves are proper codes. Every other address reads out `00`. A corrupted operand therefore gives a null result, never a believable but wrong one. An operation selector byte outside the three defined values also gives `00`. The internal working registers return to zero in every cycle that is not an evaluation, which acts as a precharge phase. The result register keeps its value between evaluations.

A caller drives both operands and the selector and raises `start_i` for one cycle. In the following cycle it reads `result_o`, qualified by `done_o`.

Top module: `drl_lut_unit`

## Requirements
- R1: While reset is asserted and right after its release, `result_o` is 0x00 and `done_o` is 0.
- R2: Output bits [7:2] are always zero. True is written `01` and false `10` in bits [1:0]. Only bits [1:0] of each operand take part, with index = (opa[1:0] << 2) | opb[1:0]. Operand bits [7:2] have no effect on the result.
- R3: Selector 0x55 (AND) returns `01` only when both operands are `01`. For the other three legal pairs it returns `10`.
- R4: Selector 0xAA (OR) returns `10` only when both operands are `10`. For the other three legal pairs it returns `01`.
- R5: Selector 0x66 (XOR) returns `01` when exactly one operand is `01`. For the other two legal pairs it returns `10`.
- R6: If either operand's low pair is `00` or `11`, the result is 0x00 for every selector value.
- R7: Any selector other than 0x55, 0xAA and 0x66 forces the result to 0x00.
- R8: `done_o` is high in exactly the cycles that follow a cycle with `start_i` high. `result_o` takes the new value at the same edge.
- R9: When no start was seen in the previous cycle, `result_o` keeps its value and the internal working registers sit at zero (precharge).
- R10: Starts in consecutive cycles are each evaluated. `done_o` stays high throughout, and the result follows each request one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate request, one cycle per request |
| opa_i | input | 8 | First operand byte, value in bits [1:0] |
| opb_i | input | 8 | Second operand byte, value in bits [1:0] |
| opsel_i | input | 8 | Function selector: 0x55 AND, 0xAA OR, 0x66 XOR |
| result_o | output | 8 | Rail-coded result, held until the next start |
| done_o | output | 1 | One-cycle flag, result updated |

## Verification
Two functions can fall in the same cycle. One is the completion flag of an earlier request. The other is a new request that reloads the result and the working registers in place of the precharge. The bench provokes this by holding `start_i` high across consecutive cycles with different operand pairs and selectors. It judges the overlap by checking that `done_o` never drops and that each cycle's `result_o` equals the value computed arithmetically for the request made one cycle earlier. The sweep covers every low-pair combination, several upper-bit patterns and legal and unknown selectors, and confirms that the result holds through idle cycles.

// File: rtl/drl_pkg.sv
package drl_pkg;

    localparam int RAIL_W = 2;
    localparam int IDX_W  = 2 * RAIL_W;
    localparam int N_IDX  = 1 << IDX_W;
    localparam int N_FN   = 3;

    localparam logic [RAIL_W-1:0] RAIL_TRUE  = 2'b01;
    localparam logic [RAIL_W-1:0] RAIL_FALSE = 2'b10;
    localparam logic [RAIL_W-1:0] RAIL_NULL  = 2'b00;

    typedef enum logic [7:0] {
        SEL_AND = 8'h55,
        SEL_OR  = 8'hAA,
        SEL_XOR = 8'h66
    } fn_sel_e;

    localparam int FN_AND = 0;
    localparam int FN_OR  = 1;
    localparam int FN_XOR = 2;

    function automatic logic rail_legal(input logic [RAIL_W-1:0] r);
        return (r == RAIL_TRUE) || (r == RAIL_FALSE);
    endfunction

    // Table content for one function at one address; computed, never listed.
    function automatic logic [RAIL_W-1:0] rail_entry(input int fn, input logic [IDX_W-1:0] idx);
        logic [RAIL_W-1:0] hi;
        logic [RAIL_W-1:0] lo;
        logic              vh;
        logic              vl;
        logic              res;
        hi = idx[IDX_W-1:RAIL_W];
        lo = idx[RAIL_W-1:0];
        if (!rail_legal(hi) || !rail_legal(lo)) begin
            return RAIL_NULL;
        end
        vh = (hi == RAIL_TRUE);
        vl = (lo == RAIL_TRUE);
        case (fn)
            FN_AND:  res = vh & vl;
            FN_OR:   res = vh | vl;
            default: res = vh ^ vl;
        endcase
        return res ? RAIL_TRUE : RAIL_FALSE;
    endfunction

endpackage

// File: rtl/drl_index_pack.sv
module drl_index_pack
    import drl_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    output logic [WORD_W-1:0] opa_m_o,
    output logic [WORD_W-1:0] opb_m_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [WORD_W-1:0] KEEP_MASK = WORD_W'((1 << RAIL_W) - 1);

    logic [WORD_W-1:0] packed_w;

    always_comb begin
        opa_m_o  = opa_i & KEEP_MASK;
        opb_m_o  = opb_i & KEEP_MASK;
        packed_w = (opa_m_o << RAIL_W) | opb_m_o;
        idx_o    = packed_w[IDX_W-1:0];
    end

    // Operand bits above the rail pair never reach the address (R2)
    always_comb begin
        p_mask_clean_r2: assert ((opa_m_o >> RAIL_W) == '0 && (opb_m_o >> RAIL_W) == '0);
    end

endmodule

// File: rtl/drl_table.sv
module drl_table
    import drl_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [RAIL_W-1:0] rail_o
);
    logic [RAIL_W-1:0] tbl [N_FN][N_IDX];

    for (genvar f = 0; f < N_FN; f++) begin : g_fn
        for (genvar i = 0; i < N_IDX; i++) begin : g_idx
            assign tbl[f][i] = rail_entry(f, IDX_W'(i));
        end
    end

    always_comb begin
        case (sel_i)
            SEL_W'(SEL_AND): rail_o = tbl[FN_AND][idx_i];
            SEL_W'(SEL_OR):  rail_o = tbl[FN_OR][idx_i];
            SEL_W'(SEL_XOR): rail_o = tbl[FN_XOR][idx_i];
            default:         rail_o = RAIL_NULL;
        endcase
    end

    // Table never emits the all-ones pair (R2)
    always_comb begin
        p_rail_code_r2: assert (rail_o != 2'b11);
    end

endmodule

// File: rtl/drl_lut_unit.sv
module drl_lut_unit
    import drl_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic [WORD_W-1:0] opsel_i,
    output logic [WORD_W-1:0] result_o,
    output logic              done_o
);
    localparam int PAD_W = WORD_W - RAIL_W;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic              done;
        logic [WORD_W-1:0] work_a;
        logic [WORD_W-1:0] work_b;
        logic [WORD_W-1:0] work_sel;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [WORD_W-1:0] opa_m;
    logic [WORD_W-1:0] opb_m;
    logic [IDX_W-1:0]  idx;
    logic [RAIL_W-1:0] rail;

    drl_index_pack #(.WORD_W(WORD_W)) pack_i (
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .opa_m_o (opa_m),
        .opb_m_o (opb_m),
        .idx_o   (idx)
    );

    drl_table #(.SEL_W(WORD_W)) table_i (
        .sel_i  (opsel_i),
        .idx_i  (idx),
        .rail_o (rail)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.work_a   = opa_m;
            st_d.work_b   = opb_m;
            st_d.work_sel = opsel_i;
            st_d.result   = {{PAD_W{1'b0}}, rail};
        end else begin
            st_d.work_a   = '0;
            st_d.work_b   = '0;
            st_d.work_sel = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign done_o   = st_q.done;

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_o[WORD_W-1:RAIL_W] == '0);

    p_done_follows_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    p_done_only_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));

    p_precharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (st_q.work_a == '0 && st_q.work_b == '0 && st_q.work_sel == '0));

    p_null_on_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (!rail_legal(opa_i[RAIL_W-1:0]) || !rail_legal(opb_i[RAIL_W-1:0])))
        |=> result_o == '0);

    p_null_on_bad_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && opsel_i != 8'h55 && opsel_i != 8'hAA && opsel_i != 8'h66)
        |=> result_o == '0);

endmodule

// File: tb/drl_lut_unit_tb_top.sv
`timescale 1ns/1ps
module drl_lut_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] opa_i = 8'h00;
    logic [7:0] opb_i = 8'h00;
    logic [7:0] opsel_i = 8'h00;
    logic [7:0] result_o;
    logic       done_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    drl_lut_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .opsel_i  (opsel_i),
        .result_o (result_o),
        .done_o   (done_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic legal(input logic [7:0] x);
        return (x[1:0] == 2'b01) || (x[1:0] == 2'b10);
    endfunction

    // Expected result from the requirements, computed arithmetically
    function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] s);
        int va;
        int vb;
        int r;
        if (!legal(a) || !legal(b)) return 8'h00;
        va = (a[1:0] == 2'b01) ? 1 : 0;
        vb = (b[1:0] == 2'b01) ? 1 : 0;
        if (s == 8'h55)      r = va * vb;
        else if (s == 8'hAA) r = (va + vb > 0) ? 1 : 0;
        else if (s == 8'h66) r = (va + vb) % 2;
        else return 8'h00;
        return (r == 1) ? 8'h01 : 8'h02;
    endfunction

    function automatic string tag_of(input logic [7:0] a, input logic [7:0] b,
                                     input logic [7:0] s);
        if (s != 8'h55 && s != 8'hAA && s != 8'h66) return "R7";
        if (!legal(a) || !legal(b)) return "R6";
        if (s == 8'h55) return "R3";
        if (s == 8'hAA) return "R4";
        return "R5";
    endfunction

    task automatic eval_one(input logic [7:0] a, input logic [7:0] b, input logic [7:0] s);
        @(negedge clk);
        start_i = 1'b1;
        opa_i = a;
        opb_i = b;
        opsel_i = s;
        @(negedge clk);
        start_i = 1'b0;
        check({"R8 done ", tag_of(a, b, s)}, {7'd0, done_o}, 8'h01);
        check(tag_of(a, b, s), result_o, model(a, b, s));
    endtask

    initial begin
        logic [7:0] uppers [3];
        logic [7:0] sels [6];
        logic [7:0] held;
        uppers = '{8'h00, 8'hFC, 8'hA4};
        sels   = '{8'h55, 8'hAA, 8'h66, 8'h00, 8'hFF, 8'h56};

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 result in reset", result_o, 8'h00);
        check("R1 done in reset", {7'd0, done_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 result after release", result_o, 8'h00);
        check("R1 done after release", {7'd0, done_o}, 8'h00);

        // Sweep: every low pair, upper-bit noise, all selectors (R2..R7)
        for (int ua = 0; ua < 3; ua++) begin
            for (int ub = 0; ub < 3; ub++) begin
                for (int sx = 0; sx < 6; sx++) begin
                    for (int la = 0; la < 4; la++) begin
                        for (int lb = 0; lb < 4; lb++) begin
                            eval_one(uppers[ua] | 8'(la), uppers[ub] | 8'(lb), sels[sx]);
                        end
                    end
                end
            end
        end

        // R2: upper operand bits ignored, compared against clean operands
        eval_one(8'hFD, 8'h5E, 8'h66);
        check("R2 noisy XOR", result_o, 8'h01);
        eval_one(8'h01, 8'h02, 8'h66);
        check("R2 clean XOR", result_o, 8'h01);

        // R9: result holds through idle cycles, done stays low
        eval_one(8'h01, 8'h01, 8'h55);
        held = result_o;
        opa_i = 8'h02;
        opb_i = 8'h03;
        opsel_i = 8'hAA;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R9 hold result", result_o, held);
            check("R8 done low when idle", {7'd0, done_o}, 8'h00);
        end

        // R10: back-to-back starts overlap completion with new request
        @(negedge clk);
        start_i = 1'b1; opa_i = 8'h02; opb_i = 8'h02; opsel_i = 8'hAA;
        @(negedge clk);
        check("R10 first result", result_o, 8'h02);
        check("R10 done first", {7'd0, done_o}, 8'h01);
        opa_i = 8'h01; opb_i = 8'h02; opsel_i = 8'h66;
        @(negedge clk);
        check("R10 second result", result_o, 8'h01);
        check("R10 done second", {7'd0, done_o}, 8'h01);
        opa_i = 8'h03; opb_i = 8'h01; opsel_i = 8'h55;
        @(negedge clk);
        check("R10 third result null", result_o, 8'h00);
        check("R10 done third", {7'd0, done_o}, 8'h01);
        start_i = 1'b0;
        @(negedge clk);
        check("R10 done drops", {7'd0, done_o}, 8'h00);
        check("R10 result held", result_o, 8'h00);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule